// File: doc/BRIEF.md
# Stereo Sample Attenuator, Router and Mute Ramp

This block sits in the digital audio path after the sample deserialiser. Each strobed pair of left and right samples first has a per-channel gain applied, set by an 8-bit code that works as a linear fraction of 256. The attenuated pair then passes through a small routing matrix that feeds each output from silence, the right input, the left input or the average of the two.

A soft-mute gain is applied last. It ramps down one step per sample while mute is requested and climbs back to unity once the request is released. The mute request combines a register mute bit, an external mute level and an automute latch, and the latch only counts when its enable is set. The automute latch sets after a long unbroken run of samples that are zero on both channels and clears on the next non-zero sample. An operation-disable bit forces both outputs to midscale (zero).

Top module: `chan_atten_route`

## Requirements
- R1: After reset, `left_o`, `right_o`, `valid_o` and `automute_o` are 0 and the soft-mute gain is at unity, so the first sample passes at full level.
- R2: For an attenuation code c below FFh, each channel is scaled to floor(x*c/256), which truncates toward minus infinity. Code 00h gives 0.
- R3: Attenuation code FFh passes the sample unchanged (0 dB).
- R4: `route_i[3:2]` selects the source for the left output and `route_i[1:0]` selects the source for the right output. For each field, 00 = zero, 01 = attenuated right, 10 = attenuated left, 11 = mix.
- R5: The mix is floor((L+R)/2), computed with one extra sign bit, so full-scale inputs of the same sign do not overflow.
- R6: `valid_o` pulses exactly two clock cycles after `valid_i`, and each output pair belongs to the strobed input pair.
- R7: `automute_o` rises on the 1024th consecutive strobed sample that is zero on both channels. It falls on the first strobed sample with any non-zero channel.
- R8: Soft mute is requested when `mute_i`, `ext_mute_i`, or `automute_o` together with `auto_en_i` is high. If `auto_en_i` is low, the automute latch has no effect on the outputs.
- R9: The soft-mute gain g is 10 bits wide, with unity at 512. Each output is floor(routed*g/512) using g as it stood before the current sample. After each sample, g falls by 1 (not below 0) while mute is requested and rises by 1 (not above 512) otherwise.
- R10: While `op_dis_i` is high, the strobed outputs are 0. `valid_o` still pulses and the gain ramp keeps stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample-pair strobe |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| att_left_i | input | 8 | Left attenuation code |
| att_right_i | input | 8 | Right attenuation code |
| route_i | input | 4 | Output routing code |
| mute_i | input | 1 | Soft-mute request |
| auto_en_i | input | 1 | Lets automute request soft mute |
| ext_mute_i | input | 1 | External mute level |
| op_dis_i | input | 1 | Forces outputs to midscale |
| valid_o | output | 1 | Output-pair strobe |
| left_o | output | 24 | Processed left sample |
| right_o | output | 24 | Processed right sample |
| automute_o | output | 1 | Zero-run automute latch |

## Verification
The hardest state to reach from the ports is the soft-mute gain partway through its ramp, just after the automute latch has fired. That point needs a run of exactly 1024 zero pairs followed by a non-zero pair. The next output must then show a gain of 511, and the pair after it must show full gain again. The bench drives these runs and the full 512-step mute and release ramps one sample at a time. It keeps its own model of the zero counter, the latch and the gain, so every intermediate output level is compared rather than only the end points.

// File: rtl/chan_atten_pkg.sv
package chan_atten_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_RIGHT = 2'b01,
    SRC_LEFT  = 2'b10,
    SRC_MIX   = 2'b11
  } src_sel_e;
endpackage

// File: rtl/chan_atten_scale.sv
module chan_atten_scale #(
  parameter int DATA_W = 24,
  parameter int ATT_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic        [ATT_W-1:0]  code_i,
  output logic signed [DATA_W-1:0] data_o
);
  localparam int PROD_W = DATA_W + ATT_W + 2;

  logic        [ATT_W:0]    gain;
  logic signed [PROD_W-1:0] prod, shifted;

  // all-ones code means exact unity instead of 255/256
  assign gain    = (&code_i) ? {1'b1, {ATT_W{1'b0}}} : {1'b0, code_i};
  assign prod    = $signed({{(PROD_W-DATA_W){data_i[DATA_W-1]}}, data_i})
                 * $signed({{(PROD_W-ATT_W-1){1'b0}}, gain});
  assign shifted = prod >>> ATT_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (valid_i) data_o <= shifted[DATA_W-1:0];
  end

  assert_scale_fits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (shifted[PROD_W-1:DATA_W-1] == '0 || shifted[PROD_W-1:DATA_W-1] == '1));
  assert_code_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && code_i == '0) |=> data_o == '0);
  assert_code_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&code_i)) |=> data_o == $past(data_i));
endmodule

// File: rtl/chan_route_sel.sv
module chan_route_sel
  import chan_atten_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  input  logic signed [DATA_W-1:0] mix_i,
  input  src_sel_e                 sel_i,
  output logic signed [DATA_W-1:0] data_o
);
  always_comb begin
    unique case (sel_i)
      SRC_RIGHT: data_o = right_i;
      SRC_LEFT:  data_o = left_i;
      SRC_MIX:   data_o = mix_i;
      default:   data_o = '0;
    endcase
  end
endmodule

// File: rtl/chan_zero_run.sv
module chan_zero_run #(
  parameter int ZERO_RUN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic zero_i,
  output logic flag_o
);
  localparam int CNT_W = $clog2(ZERO_RUN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ZERO_RUN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (valid_i) begin
      if (!zero_i) begin
        cnt_q  <= '0;
        flag_o <= 1'b0;
      end else if (cnt_q == LAST) begin
        flag_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_nonzero_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !zero_i) |=> !flag_o);
  assert_idle_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flag_o));
  assert_rise_on_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(valid_i && zero_i));
endmodule

// File: rtl/chan_gain_ramp.sv
module chan_gain_ramp #(
  parameter int GAIN_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              mute_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] UNITY = {1'b1, {(GAIN_W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_o <= UNITY;
    else if (step_i) begin
      if (mute_i && gain_o != '0)          gain_o <= gain_o - 1'b1;
      else if (!mute_i && gain_o != UNITY) gain_o <= gain_o + 1'b1;
    end
  end

  assert_gain_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_o <= UNITY);
  assert_gain_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(gain_o));
  assert_gain_falls_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mute_i) |=> gain_o <= $past(gain_o));
  assert_gain_rises_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !mute_i) |=> gain_o >= $past(gain_o));
endmodule

// File: rtl/chan_out_stage.sv
module chan_out_stage #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     dis_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic        [GAIN_W-1:0] gain_i,
  output logic signed [DATA_W-1:0] data_o
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;

  logic signed [PROD_W-1:0] prod, shifted;

  assign prod    = $signed({{(PROD_W-DATA_W){data_i[DATA_W-1]}}, data_i})
                 * $signed({{(PROD_W-GAIN_W){1'b0}}, gain_i});
  assign shifted = prod >>> (GAIN_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (valid_i) data_o <= dis_i ? '0 : shifted[DATA_W-1:0];
  end

  assert_ramp_fits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (shifted[PROD_W-1:DATA_W-1] == '0 || shifted[PROD_W-1:DATA_W-1] == '1));
  assert_disable_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dis_i) |=> data_o == '0);
endmodule

// File: rtl/chan_atten_route.sv
module chan_atten_route
  import chan_atten_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int ATT_W    = 8,
  parameter int GAIN_W   = 10,
  parameter int ZERO_RUN = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic [ATT_W-1:0]  att_left_i,
  input  logic [ATT_W-1:0]  att_right_i,
  input  logic [3:0]        route_i,
  input  logic              mute_i,
  input  logic              auto_en_i,
  input  logic              ext_mute_i,
  input  logic              op_dis_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              automute_o
);
  localparam int NCH = 2;

  logic signed [DATA_W-1:0] din    [NCH];
  logic signed [DATA_W-1:0] stg1   [NCH];
  logic signed [DATA_W-1:0] routed [NCH];
  logic signed [DATA_W-1:0] dout   [NCH];
  logic        [ATT_W-1:0]  code   [NCH];
  src_sel_e                 sel    [NCH];
  logic signed [DATA_W:0]   mix_sum;
  logic signed [DATA_W-1:0] mix;
  logic [GAIN_W-1:0]        gain;
  logic                     v1_q, am, soft_mute;

  assign din[0]  = $signed(left_i);
  assign din[1]  = $signed(right_i);
  assign code[0] = att_left_i;
  assign code[1] = att_right_i;
  assign sel[0]  = src_sel_e'(route_i[3:2]);
  assign sel[1]  = src_sel_e'(route_i[1:0]);

  // extra sign bit keeps the average from wrapping
  assign mix_sum = {stg1[0][DATA_W-1], stg1[0]} + {stg1[1][DATA_W-1], stg1[1]};
  assign mix     = mix_sum[DATA_W:1];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    chan_atten_scale #(.DATA_W(DATA_W), .ATT_W(ATT_W)) u_scale (
      .clk_i, .rst_ni, .valid_i,
      .data_i(din[ch]), .code_i(code[ch]), .data_o(stg1[ch]));
    chan_route_sel #(.DATA_W(DATA_W)) u_route (
      .left_i(stg1[0]), .right_i(stg1[1]), .mix_i(mix),
      .sel_i(sel[ch]), .data_o(routed[ch]));
    chan_out_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_out (
      .clk_i, .rst_ni, .valid_i(v1_q), .dis_i(op_dis_i),
      .data_i(routed[ch]), .gain_i(gain), .data_o(dout[ch]));
  end

  chan_zero_run #(.ZERO_RUN(ZERO_RUN)) u_zero (
    .clk_i, .rst_ni, .valid_i,
    .zero_i(left_i == '0 && right_i == '0), .flag_o(am));

  assign soft_mute = mute_i | ext_mute_i | (am & auto_en_i);

  chan_gain_ramp #(.GAIN_W(GAIN_W)) u_ramp (
    .clk_i, .rst_ni, .step_i(v1_q), .mute_i(soft_mute), .gain_o(gain));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      v1_q    <= valid_i;
      valid_o <= v1_q;
    end
  end

  assign left_o     = dout[0];
  assign right_o    = dout[1];
  assign automute_o = am;

  assert_stage1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> v1_q);
  assert_stage2_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q |=> valid_o);
  assert_left_none_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && route_i[3:2] == 2'b00) |=> left_o == '0);
  assert_right_none_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && route_i[1:0] == 2'b00) |=> right_o == '0);
  assert_no_auto_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && !mute_i && !ext_mute_i && !auto_en_i) |=> gain >= $past(gain));
endmodule

// File: tb/chan_atten_route_tb_top.sv
module chan_atten_route_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [23:0] left_i = '0, right_i = '0;
  logic [7:0]  att_left_i = 8'hFF, att_right_i = 8'hFF;
  logic [3:0]  route_i = 4'b1001;
  logic        mute_i = 0, auto_en_i = 0, ext_mute_i = 0, op_dis_i = 0;
  logic        valid_o, automute_o;
  logic [23:0] left_o, right_o;

  int     n_vec = 0, n_bad = 0;
  longint g_m = 512;
  int     zc_m = 0;
  bit     am_m = 0;
  bit     done = 0;

  always #5ns clk = ~clk;

  chan_atten_route dut_i (
    .clk_i(clk), .rst_ni, .valid_i, .left_i, .right_i, .att_left_i, .att_right_i,
    .route_i, .mute_i, .auto_en_i, .ext_mute_i, .op_dis_i,
    .valid_o, .left_o, .right_o, .automute_o);

  function automatic longint att(longint x, int c);
    longint g = (c == 255) ? 256 : c;
    return (x * g) >>> 8;
  endfunction

  function automatic longint pick(logic [1:0] s, longint l, longint r);
    case (s)
      2'b01:   return r;
      2'b10:   return l;
      2'b11:   return (l + r) >>> 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input longint l, input longint r, input string req);
    longint al, ar, el, er;
    bit sm;
    @(negedge clk);
    left_i = l[23:0]; right_i = r[23:0]; valid_i = 1'b1;
    if (l == 0 && r == 0) begin
      if (zc_m == 1023) am_m = 1; else zc_m++;
    end else begin
      zc_m = 0; am_m = 0;
    end
    sm = mute_i | ext_mute_i | (auto_en_i & am_m);
    al = att(l, att_left_i);
    ar = att(r, att_right_i);
    el = (pick(route_i[3:2], al, ar) * g_m) >>> 9;
    er = (pick(route_i[1:0], al, ar) * g_m) >>> 9;
    if (op_dis_i) begin el = 0; er = 0; end
    if (sm && g_m > 0) g_m--;
    else if (!sm && g_m < 512) g_m++;
    @(negedge clk);
    valid_i = 1'b0;
    if (valid_o !== 1'b0) check("R6", "early valid_o", valid_o, 0);
    @(negedge clk);
    if (valid_o !== 1'b1) check("R6", "valid_o", valid_o, 1);
    check(req, "left_o", longint'($signed(left_o)), el);
    check(req, "right_o", longint'($signed(right_o)), er);
    check("R7", "automute_o", automute_o, am_m);
  endtask

  task automatic t_reset();
    check("R1", "left_o", left_o, 0);
    check("R1", "right_o", right_o, 0);
    check("R1", "valid_o", valid_o, 0);
    check("R1", "automute_o", automute_o, 0);
    apply(123456, -654321, "R1");
  endtask

  task automatic t_atten();
    att_left_i = 8'h80; att_right_i = 8'h80;
    apply(1000, -1001, "R2");
    att_left_i = 8'h01; att_right_i = 8'h00;
    apply(8388607, 5000, "R2");
    att_left_i = 8'hFF; att_right_i = 8'hFE;
    apply(-8388608, 256, "R3");
    att_left_i = 8'hFF; att_right_i = 8'hFF;
    apply(8388607, -1, "R3");
  endtask

  task automatic t_route();
    route_i = 4'b0110; apply(100, -200, "R4");
    route_i = 4'b0000; apply(100, -200, "R4");
    route_i = 4'b0111; apply(10, -3, "R4");
    route_i = 4'b1111; apply(8388607, 8388607, "R5");
    apply(-8388608, -1, "R5");
    apply(-7, 2, "R5");
    route_i = 4'b1001;
  endtask

  task automatic t_opdis();
    op_dis_i = 1; apply(1234, -5, "R10");
    op_dis_i = 0; apply(1234, -5, "R10");
  endtask

  task automatic t_automute();
    auto_en_i = 0;
    for (int i = 0; i < 1100; i++) apply(0, 0, "R7");
    apply(4096, 4096, "R8");
    auto_en_i = 1;
    for (int i = 0; i < 1023; i++) apply(0, 0, "R7");
    check("R7", "flag after 1023 zeros", automute_o, 0);
    apply(0, 0, "R7");
    check("R7", "flag after 1024 zeros", automute_o, 1);
    apply(4096, 4096, "R8");
    check("R8", "gain one step down", longint'($signed(left_o)), 4088);
    apply(4096, 4096, "R8");
    check("R8", "gain back to unity", longint'($signed(left_o)), 4096);
    auto_en_i = 0;
  endtask

  task automatic t_mute_ramp();
    mute_i = 1;
    for (int i = 0; i < 520; i++) apply(1048576, -1048576, "R9");
    check("R9", "fully muted", longint'($signed(left_o)), 0);
    mute_i = 0;
    for (int i = 0; i < 520; i++) apply(1048576, -1048575, "R9");
    check("R9", "unity restored", longint'($signed(left_o)), 1048576);
  endtask

  task automatic t_ext_mute();
    ext_mute_i = 1;
    for (int i = 0; i < 10; i++) apply(-300000, 77777, "R8");
    ext_mute_i = 0;
    for (int i = 0; i < 20; i++) apply(-300000, 77777, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_atten();
    t_route();
    t_opdis();
    t_automute();
    t_mute_ramp();
    t_ext_mute();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule